// File: doc/BRIEF.md
# Bounded Parallel Match Search

This block keeps a small array of register entries and answers "which entry holds this key?" in a single clock. Each entry is a flip-flop word, so every entry is compared against the search key at the same time. A bound supplied with each search limits the search to the lowest entries of the array. When more than one entry qualifies, the entry with the highest index wins. The answer is captured in an output register.

The array is loaded one entry per clock through a write port. A search is started by pulsing a strobe together with a key and a bound. One cycle later a valid flag rises and the result register holds either the winning index or, if nothing qualified, the bound value itself. A miss is therefore told apart from a hit by comparing the result with the bound that was used: every hit is strictly below it.

Top module: `msrch_top`

## Requirements
- R1: A synchronous active-high reset `rst` clears every array entry to 0, sets `res_idx` to 0 and sets `res_valid` to 0.
- R2: When `wr_en` is high on a rising edge, entry `wr_addr` takes the value `wr_data`. No other entry changes.
- R3: A search compares the key only with entries whose index is strictly less than `srch_bound`. A bound of k enables indices 0 to k-1, and a bound of 16 searches all 16 entries.
- R4: When several enabled entries equal the key, `res_idx` takes the highest such index.
- R5: When no enabled entry equals the key, `res_idx` takes the value of `srch_bound`. A bound of 0 always gives 0.
- R6: The result of a search strobed on one rising edge is visible on `res_idx` right after that edge. `res_valid` is 1 during the cycle after a strobe and 0 during a cycle after an edge with no strobe.
- R7: `res_idx` keeps its value across edges where `srch_en` is low.
- R8: When a write and a search occur on the same edge, the search uses the contents the array held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one entry |
| wr_addr | input | 4 | Index of the entry to write |
| wr_data | input | 4 | Value to store |
| srch_en | input | 1 | Search strobe |
| srch_key | input | 4 | Value to look for |
| srch_bound | input | 5 | Number of low entries searched (0 to 16) |
| res_idx | output | 5 | Winning index, or the bound on a miss |
| res_valid | output | 1 | High for the cycle after a search strobe |

## Verification
The bench targets a bound that sits exactly on a matching index. A mask that is off by one there would report that index instead of the lower match or the bound. It also tests bounds of 0, 1 and 16, and repeated matches where a lowest-first encoder would return the wrong index. A write that hits the entry being searched in the same cycle checks whether the search sees the old value; a design that forwarded the write data would report the freshly written index one cycle too early. A miss must return the bound exactly, so a design that returned a fixed code or the last index would fail on bounds 2, 3 and 16.

// File: rtl/msrch_pkg.sv
package msrch_pkg;

  localparam int DEF_ENTRIES = 16;
  localparam int DEF_DATA_W  = 4;

  // An entry takes part in a search only when its index lies below the bound.
  function automatic logic in_window(input int idx, input int bound);
    return idx < bound;
  endfunction

  // A word matches when the two values are equal in every bit.
  function automatic logic word_eq(input logic [31:0] a, input logic [31:0] b);
    return a == b;
  endfunction

endpackage

// File: rtl/msrch_store.sv
module msrch_store #(
  parameter int ENTRIES = msrch_pkg::DEF_ENTRIES,
  parameter int DATA_W  = msrch_pkg::DEF_DATA_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [ENTRIES*DATA_W-1:0] cells_flat
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cell_q <= '0;
      end else if (wr_en && (wr_addr == IDX_W'(g))) begin
        cell_q <= wr_data;
      end
    end
    assign cells_flat[g*DATA_W +: DATA_W] = cell_q;
  end

endmodule

// File: rtl/msrch_compare.sv
module msrch_compare #(
  parameter int ENTRIES = msrch_pkg::DEF_ENTRIES,
  parameter int DATA_W  = msrch_pkg::DEF_DATA_W,
  localparam int BND_W  = $clog2(ENTRIES + 1)
) (
  input  logic [ENTRIES*DATA_W-1:0] cells_flat,
  input  logic [DATA_W-1:0]         key,
  input  logic [BND_W-1:0]          bound,
  output logic [ENTRIES-1:0]        hit_vec
);

  logic [ENTRIES-1:0] window;
  logic [ENTRIES-1:0] equal;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_lane
    // thermometer decode of the bound
    assign window[g] = msrch_pkg::in_window(g, int'(bound));
    assign equal[g]  = msrch_pkg::word_eq(32'(cells_flat[g*DATA_W +: DATA_W]), 32'(key));
    assign hit_vec[g] = window[g] & equal[g];
  end

endmodule

// File: rtl/msrch_encode.sv
module msrch_encode #(
  parameter int ENTRIES = msrch_pkg::DEF_ENTRIES,
  localparam int BND_W  = $clog2(ENTRIES + 1)
) (
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic [BND_W-1:0]   bound,
  output logic [BND_W-1:0]   pick,
  output logic               any_hit
);

  // Higher indices are visited later and overwrite lower ones.
  always_comb begin
    pick = bound;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) pick = BND_W'(i);
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/msrch_top.sv
module msrch_top #(
  parameter int ENTRIES = msrch_pkg::DEF_ENTRIES,
  parameter int DATA_W  = msrch_pkg::DEF_DATA_W,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BND_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              srch_en,
  input  logic [DATA_W-1:0] srch_key,
  input  logic [BND_W-1:0]  srch_bound,
  output logic [BND_W-1:0]  res_idx,
  output logic              res_valid
);

  logic [ENTRIES*DATA_W-1:0] cells_flat;
  logic [ENTRIES-1:0]        hit_vec;
  logic [BND_W-1:0]          pick;
  logic                      any_hit;

  msrch_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cells_flat(cells_flat)
  );

  msrch_compare #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_cmp (
    .cells_flat(cells_flat),
    .key       (srch_key),
    .bound     (srch_bound),
    .hit_vec   (hit_vec)
  );

  msrch_encode #(.ENTRIES(ENTRIES)) u_enc (
    .hit_vec(hit_vec),
    .bound  (srch_bound),
    .pick   (pick),
    .any_hit(any_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_idx   <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= srch_en;
      if (srch_en) res_idx <= pick;
    end
  end

endmodule

// File: rtl/msrch_check.sv
module msrch_check #(
  parameter int BND_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             srch_en,
  input logic [BND_W-1:0] srch_bound,
  input logic             any_hit,
  input logic [BND_W-1:0] res_idx,
  input logic             res_valid
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (res_idx == '0 && !res_valid));

  a_r6_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    srch_en |=> res_valid);

  a_r6_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> !res_valid);

  a_r4_hit_below_bound: assert property (@(posedge clk) disable iff (rst)
    (srch_en && any_hit) |=> (res_idx < $past(srch_bound)));

  a_r5_miss_returns_bound: assert property (@(posedge clk) disable iff (rst)
    (srch_en && !any_hit) |=> (res_idx == $past(srch_bound)));

  a_r5_zero_bound: assert property (@(posedge clk) disable iff (rst)
    (srch_en && srch_bound == '0) |=> (res_idx == '0));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> $stable(res_idx));

endmodule

bind msrch_top msrch_check #(.BND_W(BND_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .srch_en   (srch_en),
  .srch_bound(srch_bound),
  .any_hit   (any_hit),
  .res_idx   (res_idx),
  .res_valid (res_valid)
);

// File: tb/test_msrch_top.sv
module test_msrch_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       srch_en = 1'b0;
  logic [3:0] srch_key = '0;
  logic [4:0] srch_bound = '0;
  logic [4:0] res_idx;
  logic       res_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  msrch_top i_msrch_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .srch_en(srch_en), .srch_key(srch_key), .srch_bound(srch_bound),
    .res_idx(res_idx), .res_valid(res_valid)
  );

  // {key[13:10], bound[9:5], expected[4:0]} ; array holds entry i = i mod 4
  localparam int NVEC = 12;
  localparam logic [13:0] VEC [NVEC] = '{
    {4'd2, 5'd16, 5'd14},  // R3/R4 full range, highest of 2,6,10,14
    {4'd2, 5'd14, 5'd10},  // R3 bound sits on a match
    {4'd2, 5'd15, 5'd14},  // R3 bound one past a match
    {4'd2, 5'd3,  5'd2},   // R3 only lowest match enabled
    {4'd2, 5'd2,  5'd2},   // R5 miss, bound returned
    {4'd0, 5'd0,  5'd0},   // R5 bound 0
    {4'd0, 5'd1,  5'd0},   // R3 bound 1, index 0 matches
    {4'd3, 5'd16, 5'd15},  // R4 top index wins
    {4'd5, 5'd16, 5'd16},  // R5 miss on whole array
    {4'd1, 5'd9,  5'd5},   // R3 index 9 excluded
    {4'd3, 5'd3,  5'd3},   // R5 miss, bound 3
    {4'd1, 5'd10, 5'd9}    // R4 highest of 1,5,9
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_entry(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // strobe one search, return the result sampled after the capturing edge
  task automatic search(input logic [3:0] k, input logic [4:0] b, output logic [4:0] r);
    @(negedge clk);
    srch_en = 1'b1; srch_key = k; srch_bound = b;
    @(posedge clk);
    #2;
    r = res_idx;
    check("R6 valid after strobe", 5'(res_valid), 5'd1);
    @(negedge clk);
    srch_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] r;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset idx", res_idx, 5'd0);
    check("R1 reset valid", 5'(res_valid), 5'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) write_entry(4'(i), 4'(i % 4));

    for (int v = 0; v < NVEC; v++) begin
      search(VEC[v][13:10], VEC[v][9:5], r);
      check($sformatf("R3/R4/R5 vector %0d", v), r, VEC[v][4:0]);
    end

    // R6/R7: an idle cycle drops valid and holds the result
    search(4'd1, 5'd10, r);
    @(posedge clk);
    #2;
    check("R6 valid drops when idle", 5'(res_valid), 5'd0);
    check("R7 result held", res_idx, 5'd9);

    // R2: a write lands in the addressed entry only
    write_entry(4'd7, 4'd9);
    search(4'd9, 5'd16, r);
    check("R2 written entry found", r, 5'd7);
    search(4'd3, 5'd16, r);
    check("R2 neighbour unchanged", r, 5'd15);

    // R8: search on the same edge as a write sees the old value
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd15; wr_data = 4'd9;
    srch_en = 1'b1; srch_key = 4'd9; srch_bound = 5'd16;
    @(posedge clk);
    #2;
    check("R8 old contents searched", res_idx, 5'd7);
    @(negedge clk);
    wr_en = 1'b0; srch_en = 1'b0;
    search(4'd9, 5'd16, r);
    check("R8 new contents next search", r, 5'd15);

    // R1: reset clears the array
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset idx again", res_idx, 5'd0);
    search(4'd0, 5'd16, r);
    check("R1 all entries zero", r, 5'd15);
    search(4'd9, 5'd16, r);
    check("R1 old value gone", r, 5'd16);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule